// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Protection

This block turns a virtual address into a physical address by searching every stored page mapping in parallel. The low page-offset bits pass straight through. The virtual page number is compared against all valid entries, and the physical page number of the matching entry replaces it. Every lookup also carries an access type (read or write) and a privilege mode (user or kernel). The result counts as a translation only when the matching entry allows that combination. A matching entry that does not allow it produces a protection fault instead.

An external table walker owns the contents. It installs mappings through a refill port and removes them through an invalidate port, either one page at a time or all at once. Each entry carries a reference bit. Hardware sets that bit whenever a lookup matches the entry. Software can clear all reference bits in a single cycle, which gives an approximate least-recently-used sampling scheme. The refill victim is chosen from the valid and reference bits. With the default parameters the buffer holds 128 entries, pages are 8 KB (13 offset bits), and a 28-bit physical page number yields a 41-bit physical address.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses. Before the first lookup completes, `resValid` and `resPa` are zero.
- R2: A lookup presented in one cycle produces its result in the next cycle. In that cycle `resValid` is high and exactly one of `resHit`, `resMiss` and `resFault` is high. In any other cycle all four are low.
- R3: On a permitted match, `resPa` equals the entry's physical page number concatenated with the low OFF_W bits of the lookup address.
- R4: When no valid entry holds the lookup's page number, `resMiss` is set and `resPa` is zero.
- R5: Permission bits are encoded as follows: `fillPerm[0]` = user read, `[1]` = user write, `[2]` = kernel read, `[3]` = kernel write. A match whose bit for the current mode and access type is clear raises `resFault` with `resPa` zero.
- R6: Any lookup that matches a valid entry sets that entry's reference bit, including a lookup that faults.
- R7: A pulse on `refClear` clears every reference bit in one cycle. A match or a refill in the same cycle still sets its own entry's bit.
- R8: A refill writes the lowest-index invalid entry. If every entry is valid, it writes the lowest-index entry whose reference bit is clear. If every reference bit is set, it writes entry 0. The written entry becomes valid with its reference bit set.
- R9: A refill whose page number is already held by a valid entry overwrites that entry, so no page number is ever stored twice.
- R10: An invalidate request removes the valid entry holding `invalVpn`. A request naming an absent page changes nothing.
- R11: `invalAll` clears every valid bit in one cycle.
- R12: When requests coincide in one cycle, `invalAll` takes priority over a single invalidate, which takes priority over a refill. The lower-priority requests in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVa | input | VA_W | Virtual address to translate |
| lookupWrite | input | 1 | 1 = write access, 0 = read |
| lookupUser | input | 1 | 1 = user mode, 0 = kernel mode |
| resValid | output | 1 | Lookup result present |
| resHit | output | 1 | Permitted translation |
| resMiss | output | 1 | No matching entry |
| resFault | output | 1 | Match without permission |
| resPa | output | PPN_W+OFF_W | Physical address, zero unless resHit |
| fillValid | input | 1 | Refill request |
| fillVpn | input | VA_W-OFF_W | Page number to install |
| fillPpn | input | PPN_W | Physical page number to install |
| fillPerm | input | 4 | Permission bits (see R5) |
| invalValid | input | 1 | Single-page invalidate request |
| invalVpn | input | VA_W-OFF_W | Page number to remove |
| invalAll | input | 1 | Invalidate every entry |
| refClear | input | 1 | Clear all reference bits |

## Verification
The bench builds the buffer with 4 entries, a 20-bit virtual address, 13 offset bits and an 8-bit physical page number. At that size a few refills fill the whole table, so every branch of the victim rule can be reached in a short directed run: an invalid slot, a clear reference bit, and all bits set. The 4-bit permission field is swept over all 16 values in both modes and for both access types. Every lookup is compared with a small page model kept in the bench.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PERM_W = 4;
  localparam int PERM_UR = 0;
  localparam int PERM_UW = 1;
  localparam int PERM_KR = 2;
  localparam int PERM_KW = 3;

  typedef struct packed {
    logic killAll;
    logic killOne;
    logic fillEn;
    logic refClr;
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillReq,
  input  logic               invalReq,
  input  logic               invalAllReq,
  input  logic               refClrReq,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] refVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  input  logic [ENTRIES-1:0] invalHitVec,
  output xlatStrobe_t        strobe,
  output logic [IDX_W-1:0]   fillIdx,
  output logic [IDX_W-1:0]   killIdx
);
  function automatic logic [IDX_W-1:0] lowIdx(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    if (|fillHitVec)       fillIdx = lowIdx(fillHitVec);
    else if (!(&validVec)) fillIdx = lowIdx(~validVec);
    else if (!(&refVec))   fillIdx = lowIdx(~refVec);
    else                   fillIdx = '0;
  end

  assign killIdx        = lowIdx(invalHitVec);
  assign strobe.killAll = invalAllReq;
  assign strobe.killOne = invalReq && !invalAllReq && (|invalHitVec);
  assign strobe.fillEn  = fillReq && !invalAllReq && !invalReq;
  assign strobe.refClr  = refClrReq;

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillEn && !(|fillHitVec) && !(&validVec)) |-> !validVec[fillIdx]) else $error("victim"); // R8
endmodule

// File: rtl/xlat_data.sv
module xlat_data
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VA_W = 48,
  parameter int OFF_W = 13,
  parameter int PPN_W = 28,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlatStrobe_t        strobe,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [IDX_W-1:0]   killIdx,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [PERM_W-1:0]  fillPerm,
  input  logic [VPN_W-1:0]   invalVpn,
  input  logic               lookupValid,
  input  logic [VA_W-1:0]    lookupVa,
  input  logic               lookupWrite,
  input  logic               lookupUser,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] refVec,
  output logic [ENTRIES-1:0] fillHitVec,
  output logic [ENTRIES-1:0] invalHitVec,
  output logic               resValid,
  output logic               resHit,
  output logic               resMiss,
  output logic               resFault,
  output logic [PA_W-1:0]    resPa
);
  logic [VPN_W-1:0]  entVpn  [ENTRIES];
  logic [PPN_W-1:0]  entPpn  [ENTRIES];
  logic [PERM_W-1:0] entPerm [ENTRIES];
  logic [ENTRIES-1:0] lookMatch;
  logic [VPN_W-1:0]  lookVpn;
  logic [OFF_W-1:0]  lookOff;
  logic [PPN_W-1:0]  selPpn;
  logic [PERM_W-1:0] selPerm;
  logic              anyMatch, permOk;

  assign lookVpn = lookupVa[VA_W-1:OFF_W];
  assign lookOff = lookupVa[OFF_W-1:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEnt
    assign lookMatch[g]   = validVec[g] && (entVpn[g] == lookVpn);
    assign fillHitVec[g]  = validVec[g] && (entVpn[g] == fillVpn);
    assign invalHitVec[g] = validVec[g] && (entVpn[g] == invalVpn);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
        refVec[g]   <= 1'b0;
      end else begin
        if (strobe.killAll) validVec[g] <= 1'b0;
        else if (strobe.killOne && killIdx == IDX_W'(g)) validVec[g] <= 1'b0;
        else if (strobe.fillEn && fillIdx == IDX_W'(g)) validVec[g] <= 1'b1;

        if (strobe.fillEn && fillIdx == IDX_W'(g)) refVec[g] <= 1'b1;
        else if (lookupValid && lookMatch[g])     refVec[g] <= 1'b1;
        else if (strobe.refClr)                   refVec[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.fillEn && fillIdx == IDX_W'(g)) begin
        entVpn[g]  <= fillVpn;
        entPpn[g]  <= fillPpn;
        entPerm[g] <= fillPerm;
      end
    end
  end

  always_comb begin
    selPpn  = '0;
    selPerm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookMatch[i]) begin
        selPpn  = selPpn | entPpn[i];
        selPerm = selPerm | entPerm[i];
      end
    end
  end

  assign anyMatch = |lookMatch;
  assign permOk = lookupUser ? (lookupWrite ? selPerm[PERM_UW] : selPerm[PERM_UR])
                             : (lookupWrite ? selPerm[PERM_KW] : selPerm[PERM_KR]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resHit   <= 1'b0;
      resMiss  <= 1'b0;
      resFault <= 1'b0;
      resPa    <= '0;
    end else begin
      resValid <= lookupValid;
      resHit   <= lookupValid && anyMatch && permOk;
      resFault <= lookupValid && anyMatch && !permOk;
      resMiss  <= lookupValid && !anyMatch;
      resPa    <= (lookupValid && anyMatch && permOk) ? {selPpn, lookOff} : '0;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> resValid) else $error("latency"); // R2
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $countones({resHit, resMiss, resFault}) == 1) else $error("one"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !(resHit || resMiss || resFault)) else $error("idle"); // R2
  AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (!resHit || resPa[OFF_W-1:0] == $past(lookOff))) else $error("offset"); // R3
  AST_PA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> resPa == '0) else $error("pa zero"); // R4
  AST_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch)) else $error("duplicate"); // R9
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.killAll |=> validVec == '0) else $error("flush"); // R11
  AST_REF_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.refClr && !strobe.fillEn && !lookupValid) |=> refVec == '0) else $error("ref"); // R7
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> (validVec[$past(fillIdx)] && refVec[$past(fillIdx)])) else $error("fill"); // R8
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int VA_W = 48,
  parameter int OFF_W = 13,
  parameter int PPN_W = 28,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic              lookupWrite,
  input  logic              lookupUser,
  output logic              resValid,
  output logic              resHit,
  output logic              resMiss,
  output logic              resFault,
  output logic [PA_W-1:0]   resPa,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [PERM_W-1:0] fillPerm,
  input  logic              invalValid,
  input  logic [VPN_W-1:0]  invalVpn,
  input  logic              invalAll,
  input  logic              refClear
);
  xlatStrobe_t        strobe;
  logic [IDX_W-1:0]   fillIdx, killIdx;
  logic [ENTRIES-1:0] validVec, refVec, fillHitVec, invalHitVec;

  xlat_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .fillReq(fillValid), .invalReq(invalValid), .invalAllReq(invalAll),
    .refClrReq(refClear), .validVec(validVec), .refVec(refVec),
    .fillHitVec(fillHitVec), .invalHitVec(invalHitVec),
    .strobe(strobe), .fillIdx(fillIdx), .killIdx(killIdx)
  );

  xlat_data #(.ENTRIES(ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fillIdx(fillIdx), .killIdx(killIdx),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillPerm(fillPerm), .invalVpn(invalVpn),
    .lookupValid(lookupValid), .lookupVa(lookupVa), .lookupWrite(lookupWrite),
    .lookupUser(lookupUser), .validVec(validVec), .refVec(refVec),
    .fillHitVec(fillHitVec), .invalHitVec(invalHitVec),
    .resValid(resValid), .resHit(resHit), .resMiss(resMiss), .resFault(resFault),
    .resPa(resPa)
  );
endmodule

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;
  localparam int N = 4;
  localparam int VA_W = 20;
  localparam int OFF_W = 13;
  localparam int PPN_W = 8;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W = PPN_W + OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0, lookupWrite = 1'b0, lookupUser = 1'b0;
  logic [VA_W-1:0] lookupVa = '0;
  logic resValid, resHit, resMiss, resFault;
  logic [PA_W-1:0] resPa;
  logic fillValid = 1'b0, invalValid = 1'b0, invalAll = 1'b0, refClear = 1'b0;
  logic [VPN_W-1:0] fillVpn = '0, invalVpn = '0;
  logic [PPN_W-1:0] fillPpn = '0;
  logic [3:0] fillPerm = '0;

  int nChecks = 0;
  int nErrors = 0;

  logic             mValid [N];
  logic             mRef   [N];
  logic [VPN_W-1:0] mVpn   [N];
  logic [PPN_W-1:0] mPpn   [N];
  logic [3:0]       mPerm  [N];

  always #4 clk = ~clk;

  xlat_buffer #(.ENTRIES(N), .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
    .lookupWrite(lookupWrite), .lookupUser(lookupUser), .resValid(resValid),
    .resHit(resHit), .resMiss(resMiss), .resFault(resFault), .resPa(resPa),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn), .fillPerm(fillPerm),
    .invalValid(invalValid), .invalVpn(invalVpn), .invalAll(invalAll), .refClear(refClear)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Victim rule of R8/R9 applied to the bench model
  task automatic modelFill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic [3:0] pm);
    int idx;
    idx = -1;
    for (int i = 0; i < N; i++) if (idx < 0 && mValid[i] && mVpn[i] == v) idx = i;
    for (int i = 0; i < N; i++) if (idx < 0 && !mValid[i]) idx = i;
    for (int i = 0; i < N; i++) if (idx < 0 && !mRef[i]) idx = i;
    if (idx < 0) idx = 0;
    mValid[idx] = 1'b1; mRef[idx] = 1'b1;
    mVpn[idx] = v; mPpn[idx] = p; mPerm[idx] = pm;
  endtask

  task automatic doFill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p, input logic [3:0] pm);
    @(negedge clk);
    fillValid = 1'b1; fillVpn = v; fillPpn = p; fillPerm = pm;
    @(negedge clk);
    fillValid = 1'b0;
    modelFill(v, p, pm);
  endtask

  task automatic doLookup(input string req, input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off,
                          input logic wr, input logic usr);
    int idx;
    int bitSel;
    logic [63:0] exp;
    idx = -1;
    for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == v) idx = i;
    bitSel = usr ? (wr ? 1 : 0) : (wr ? 3 : 2);
    if (idx < 0) exp = {40'd0, 1'b1, 1'b0, 1'b1, 1'b0, {PA_W{1'b0}}};
    else if (mPerm[idx][bitSel]) exp = {40'd0, 1'b1, 1'b1, 1'b0, 1'b0, mPpn[idx], off};
    else exp = {40'd0, 1'b1, 1'b0, 1'b0, 1'b1, {PA_W{1'b0}}};
    if (idx >= 0) mRef[idx] = 1'b1;
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = {v, off}; lookupWrite = wr; lookupUser = usr;
    @(negedge clk);
    lookupValid = 1'b0;
    check(req, {40'd0, resValid, resHit, resMiss, resFault, resPa}, exp);
  endtask

  task automatic pulseRefClear;
    @(negedge clk); refClear = 1'b1;
    @(negedge clk); refClear = 1'b0;
    for (int i = 0; i < N; i++) mRef[i] = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 1'b0; mRef[i] = 1'b0; mVpn[i] = '0; mPpn[i] = '0; mPerm[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {resValid, resPa}, '0);
    doLookup("R1 empty table misses", 7'd3, 13'h0, 1'b0, 1'b1);
    @(negedge clk);
    check("R2 no result without lookup", {resValid, resHit, resMiss, resFault}, '0);

    // R3: offset pass-through over several patterns
    doFill(7'd10, 8'hA1, 4'hF);
    doLookup("R3 offset zero", 7'd10, 13'h0000, 1'b0, 1'b0);
    doLookup("R3 offset max", 7'd10, 13'h1FFF, 1'b1, 1'b1);
    doLookup("R3 offset mid", 7'd10, 13'h1234, 1'b0, 1'b1);
    doLookup("R4 unmapped page", 7'd11, 13'h0ABC, 1'b0, 1'b0);

    // R5 sweep; each refill of the same page overwrites one entry (R9)
    for (int p = 0; p < 16; p++) begin
      doFill(7'd10, 8'(p + 8'h30), 4'(p));
      for (int u = 0; u < 2; u++)
        for (int w = 0; w < 2; w++)
          doLookup("R5 permission sweep", 7'd10, 13'(p * 37 + u * 5 + w), w[0], u[0]);
    end

    // R9: three new pages must fit beside the single swept entry
    doFill(7'd20, 8'hB2, 4'hF);
    doFill(7'd30, 8'hC3, 4'hF);
    doFill(7'd40, 8'hD4, 4'hF);
    doLookup("R9 swept page kept", 7'd10, 13'h5, 1'b0, 1'b0);
    doLookup("R9 page B", 7'd20, 13'h6, 1'b0, 1'b0);
    doLookup("R9 page C", 7'd30, 13'h7, 1'b0, 1'b0);
    doLookup("R9 page D", 7'd40, 13'h8, 1'b0, 1'b0);

    // R8: all valid, all referenced -> entry 0 replaced
    doFill(7'd50, 8'hE5, 4'b0001);
    doLookup("R8 entry 0 evicted", 7'd10, 13'h9, 1'b0, 1'b0);
    doLookup("R8 new page present", 7'd50, 13'h10, 1'b0, 1'b1);

    // R7 and R6: clear, re-reference entries 0 (via a fault) and 1
    pulseRefClear();
    doLookup("R6 faulting lookup", 7'd50, 13'h11, 1'b1, 1'b0);
    doLookup("R6 hit lookup", 7'd20, 13'h12, 1'b0, 1'b0);
    doFill(7'd60, 8'hF6, 4'hF);
    doLookup("R7 lowest clear ref evicted", 7'd30, 13'h13, 1'b0, 1'b0);
    doLookup("R6 faulted entry kept", 7'd50, 13'h14, 1'b0, 1'b1);
    doLookup("R7 entry 3 kept", 7'd40, 13'h15, 1'b0, 1'b0);
    doLookup("R7 new page", 7'd60, 13'h16, 1'b1, 1'b1);

    // R10: single invalidate, absent page, refill into freed slot
    @(negedge clk); invalValid = 1'b1; invalVpn = 7'd40;
    @(negedge clk); invalValid = 1'b0;
    for (int i = 0; i < N; i++) if (mVpn[i] == 7'd40) mValid[i] = 1'b0;
    doLookup("R10 removed page misses", 7'd40, 13'h17, 1'b0, 1'b0);
    @(negedge clk); invalValid = 1'b1; invalVpn = 7'd99;
    @(negedge clk); invalValid = 1'b0;
    doLookup("R10 absent invalidate harmless", 7'd20, 13'h18, 1'b0, 1'b0);
    doLookup("R10 absent invalidate harmless", 7'd60, 13'h19, 1'b0, 1'b0);
    doFill(7'd70, 8'h77, 4'hF);
    doLookup("R10 freed slot reused", 7'd70, 13'h1A, 1'b0, 1'b0);
    doLookup("R10 others kept", 7'd50, 13'h1B, 1'b0, 1'b1);

    // R12: single invalidate beats refill
    @(negedge clk);
    invalValid = 1'b1; invalVpn = 7'd20; fillValid = 1'b1; fillVpn = 7'd80; fillPpn = 8'h88; fillPerm = 4'hF;
    @(negedge clk);
    invalValid = 1'b0; fillValid = 1'b0;
    for (int i = 0; i < N; i++) if (mVpn[i] == 7'd20) mValid[i] = 1'b0;
    doLookup("R12 invalidate applied", 7'd20, 13'h1C, 1'b0, 1'b0);
    doLookup("R12 refill dropped", 7'd80, 13'h1D, 1'b0, 1'b0);

    // R11 with R12: flush-all beats refill and a single invalidate
    @(negedge clk);
    invalAll = 1'b1; invalValid = 1'b1; invalVpn = 7'd50; fillValid = 1'b1; fillVpn = 7'd90;
    @(negedge clk);
    invalAll = 1'b0; invalValid = 1'b0; fillValid = 1'b0;
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    doLookup("R12 refill dropped under flush", 7'd90, 13'h1E, 1'b0, 1'b0);
    doLookup("R11 flush removed", 7'd50, 13'h1F, 1'b0, 1'b1);
    doLookup("R11 flush removed", 7'd60, 13'h20, 1'b0, 1'b0);
    doLookup("R11 flush removed", 7'd70, 13'h21, 1'b0, 1'b0);
    doFill(7'd5, 8'h55, 4'b0100);
    doLookup("R11 refill after flush", 7'd5, 13'h22, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule